// File: doc/BRIEF.md
# Slave Exchange Monitor and Watchdog

This block watches the requests that reach one fieldbus slave. It receives two single-cycle strobes. One marks a data-exchange request and the other marks a write-parameter request. Each strobe arrives already decoded, error-free and addressed to this slave. Either strobe restarts a timeout counter. The counter is driven by an internal timebase that produces one tick every `TICK_DIV` clock cycles. If `TIMEOUT_TICKS` ticks pass with no strobe, the block raises a "no exchange" status for the LED logic.

The same timer can also work as a watchdog. A stored configuration flag can enable watchdog mode. A parameter port bit, synchronised through two flip-flops, can also enable it. In watchdog mode, each expiry also sends a device reset request as a pulse of fixed width. The timer stays at zero while the pulse is high. It starts counting again once the pulse ends.

Top module: `comm_watchdog`

## Requirements
- R1: After reset, `no_exch` and `reset_req` are both 0.
- R2: With no strobe, `no_exch` rises exactly `TIMEOUT_TICKS*TICK_DIV` clock cycles after the edge that sampled the last strobe.
- R3: A `dx_req` strobe restarts the timeout, so the full window is counted again from that strobe.
- R4: A `wp_req` strobe restarts the timeout in the same way as `dx_req`.
- R5: `no_exch`, once set, reads 0 in the cycle after the first strobe of either kind.
- R6: When neither `cfg_wd_en` nor the synchronised `p0_wd` is 1, expiry never raises `reset_req`, and `no_exch` stays at 1 until a strobe arrives.
- R7: With `cfg_wd_en`=1, expiry raises `reset_req` in the same cycle as `no_exch`, and it stays high for exactly `RST_PULSE_W` cycles.
- R8: `p0_wd`=1 enables watchdog mode after two clock edges of synchronisation, even with `cfg_wd_en`=0.
- R9: In watchdog mode with no strobes, successive reset pulses start `RST_PULSE_W + TIMEOUT_TICKS*TICK_DIV` cycles apart, because the timer restarts from zero after each pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dx_req | input | 1 | Qualified data-exchange request strobe |
| wp_req | input | 1 | Qualified write-parameter request strobe |
| cfg_wd_en | input | 1 | Stored watchdog enable flag |
| p0_wd | input | 1 | Asynchronous watchdog enable from parameter port bit 0 |
| no_exch | output | 1 | No-exchange status for the LED logic |
| reset_req | output | 1 | Device reset request pulse |

## Verification
Every result is registered. Status and reset respond on the first edge that samples a strobe or an expiry, and a change on `p0_wd` takes effect only after two further edges. The bench drives inputs on falling edges. It counts falling edges from the one just after the strobe-sampling edge. It samples both outputs one edge before and exactly on the cycle where each change is due, which is `TIMEOUT_TICKS*TICK_DIV` cycles for expiry and `RST_PULSE_W` cycles for the pulse width. This pins each result to the exact cycle rather than to a range of cycles.

// File: rtl/comm_watchdog.sv
module comm_watchdog #(
  parameter int TICK_DIV      = 4000,
  parameter int TIMEOUT_TICKS = 41,
  parameter int RST_PULSE_W   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dx_req,
  input  logic wp_req,
  input  logic cfg_wd_en,
  input  logic p0_wd,
  output logic no_exch,
  output logic reset_req
);
  localparam int PW = $clog2(TICK_DIV > 1 ? TICK_DIV : 2);
  localparam int TW = $clog2(TIMEOUT_TICKS > 1 ? TIMEOUT_TICKS : 2);
  localparam int RW = $clog2(RST_PULSE_W + 1);

  logic [1:0]    p0_q;
  logic [PW-1:0] pre;
  logic [TW-1:0] tcnt;
  logic [RW-1:0] rst_left;
  logic          wd_mode, rearm, tick, last, hold;

  assign wd_mode   = cfg_wd_en | p0_q[1];
  assign rearm     = dx_req | wp_req;
  assign tick      = (pre == PW'(TICK_DIV - 1));
  assign last      = (tcnt == TW'(TIMEOUT_TICKS - 1));
  assign hold      = (rst_left != '0) | (no_exch & ~wd_mode);
  assign reset_req = (rst_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p0_q     <= '0;
      pre      <= '0;
      tcnt     <= '0;
      rst_left <= '0;
      no_exch  <= 1'b0;
    end else begin
      p0_q <= {p0_q[0], p0_wd};
      if (rst_left != '0) rst_left <= rst_left - 1'b1;
      if (rearm) begin
        pre     <= '0;
        tcnt    <= '0;
        no_exch <= 1'b0;
      end else if (hold) begin
        pre  <= '0;
        tcnt <= '0;
      end else if (tick) begin
        pre <= '0;
        if (last) begin
          tcnt    <= '0;
          no_exch <= 1'b1;
          if (wd_mode) rst_left <= RW'(RST_PULSE_W);
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/comm_watchdog_chk.sv
module comm_watchdog_chk #(
  parameter int RST_PULSE_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic dx_req,
  input logic wp_req,
  input logic no_exch,
  input logic reset_req,
  input logic wd_mode
);
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= 0;
    else if (reset_req) hi_cnt <= hi_cnt + 1;
    else hi_cnt <= 0;
  end

  always_comb assert_pulse_bound_R7: assert (hi_cnt <= RST_PULSE_W);

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_req) |-> hi_cnt == RST_PULSE_W);

  assert_pulse_with_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> no_exch);

  assert_clear_on_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_req || wp_req) |=> !no_exch);

  assert_no_set_on_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_exch) |-> !$past(dx_req || wp_req));

  assert_monitor_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(wd_mode));
endmodule

bind comm_watchdog comm_watchdog_chk #(.RST_PULSE_W(RST_PULSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dx_req(dx_req), .wp_req(wp_req),
  .no_exch(no_exch), .reset_req(reset_req), .wd_mode(wd_mode)
);

// File: tb/comm_watchdog_test.sv
module comm_watchdog_test;
  localparam int DIV = 4;
  localparam int TO  = 5;
  localparam int PW  = 3;
  localparam int TD  = DIV * TO;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dx_req = 1'b0, wp_req = 1'b0, cfg_wd_en = 1'b0, p0_wd = 1'b0;
  logic no_exch, reset_req;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  comm_watchdog #(.TICK_DIV(DIV), .TIMEOUT_TICKS(TO), .RST_PULSE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .dx_req(dx_req), .wp_req(wp_req),
    .cfg_wd_en(cfg_wd_en), .p0_wd(p0_wd), .no_exch(no_exch), .reset_req(reset_req));

  task automatic chk(string rq, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(bit use_wp);
    @(negedge clk);
    if (use_wp) wp_req = 1'b1; else dx_req = 1'b1;
    @(negedge clk);
    dx_req = 1'b0;
    wp_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 no_exch", no_exch, 1'b0);
    chk("R1 reset_req", reset_req, 1'b0);
  endtask

  task automatic t_timeout_monitor;
    strobe(0);
    waitn(TD - 1);
    chk("R2 before", no_exch, 1'b0);
    waitn(1);
    chk("R2 at", no_exch, 1'b1);
    chk("R6 no pulse", reset_req, 1'b0);
    for (int i = 0; i < 3 * TD; i++) begin
      waitn(1);
      if (reset_req !== 1'b0 || no_exch !== 1'b1) begin
        chk("R6 held", reset_req | ~no_exch, 1'b0);
        break;
      end
    end
    chk("R6 stays set", no_exch, 1'b1);
  endtask

  task automatic t_clear;
    strobe(1);
    chk("R5 cleared", no_exch, 1'b0);
  endtask

  task automatic t_rearm(bit use_wp);
    string rq = use_wp ? "R4" : "R3";
    strobe(use_wp);
    waitn(TD - 5);
    strobe(use_wp);
    waitn(TD - 1);
    chk({rq, " before"}, no_exch, 1'b0);
    waitn(1);
    chk({rq, " at"}, no_exch, 1'b1);
  endtask

  task automatic pulse_check(string rq);
    for (int i = 0; i < PW; i++) begin
      chk({rq, " pulse high"}, reset_req, 1'b1);
      waitn(1);
    end
    chk({rq, " pulse end"}, reset_req, 1'b0);
  endtask

  task automatic t_wd_cfg;
    cfg_wd_en = 1'b1;
    strobe(0);
    waitn(TD - 1);
    chk("R7 before", reset_req, 1'b0);
    waitn(1);
    chk("R7 status", no_exch, 1'b1);
    pulse_check("R7");
    waitn(TD - 1);
    chk("R9 before", reset_req, 1'b0);
    waitn(1);
    chk("R9 next pulse", reset_req, 1'b1);
    waitn(PW + 1);
    cfg_wd_en = 1'b0;
    waitn(2);
  endtask

  task automatic t_wd_p0;
    p0_wd = 1'b1;
    waitn(2);
    strobe(0);
    waitn(TD);
    chk("R8 status", no_exch, 1'b1);
    pulse_check("R8");
    p0_wd = 1'b0;
    waitn(3);
    strobe(1);
    waitn(TD);
    chk("R8 off status", no_exch, 1'b1);
    chk("R8 off no pulse", reset_req, 1'b0);
  endtask

  initial begin
    waitn(3);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_timeout_monitor;
    t_clear;
    t_rearm(0);
    t_rearm(1);
    t_wd_cfg;
    t_wd_p0;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule